// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox Bank

This unit holds a bank of 32-bit doorbell mailboxes, four per core across four cores, that cores use to signal one another. A sender posts bits into a target mailbox by writing to that mailbox's set address. The receiver acknowledges by writing to the mailbox's clear address. Because posting and acknowledging go through separate addresses, a sender can add new bits while a receiver removes old ones, and no bit is lost in the overlap.

Each mailbox drives one level flag that stays high while any of its bits is 1. The flags go to a separate interrupt router, so this unit has no enable logic and gives no meaning to the bits it stores.

Writes arrive on several independent write ports (two by default), so set and clear operations can land in the same cycle. Reads come through one combinational read port. The usual receive loop has four steps: read the mailbox through its clear address, pick the lowest set bit, write that single bit back to the clear address, and repeat until the flag drops.

Top module: `mbox_doorbell_unit`

## Requirements
- R1: After reset, every mailbox reads as zero and all 16 flag bits are 0.
- R2: An aligned write to byte address 0x80 + 16*core + 4*slot on any write port ORs the write data into that mailbox on the next clock edge. All other mailboxes keep their values.
- R3: An aligned write to byte address 0xC0 + 16*core + 4*slot clears, on the next clock edge, each bit of that mailbox whose write-data bit is 1. Bits written as 0 keep their values.
- R4: While the read enable is high and the read address is an aligned clear-window address, the read data shows that mailbox's current value in the same cycle.
- R5: A read of any set-window address, or of any address outside both windows, returns zero.
- R6: Flag bit core*4+slot is high exactly when the mailbox at that core and slot is nonzero. A write changes the flag one clock edge after it is issued.
- R7: When a set and a clear reach the same mailbox in one cycle, the new value is (old | set data) & ~clear data. On overlapping bits the clear wins, whichever port carries which operation.
- R8: When several ports set the same mailbox in one cycle, all of their data bits are ORed in.
- R9: Writes with byte-address bits [1:0] not equal to zero, and writes below 0x80, change no mailbox.
- R10: Clearing bits one at a time, lowest first, keeps the flag high until the last set bit is cleared. The flag then drops on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | NUM_WR_PORTS | Write enable, one bit per write port |
| wrAddr | input | NUM_WR_PORTS*8 | Byte addresses; port p uses bits [8p+7:8p] |
| wrData | input | NUM_WR_PORTS*32 | Write data; port p uses bits [32p+31:32p] |
| rdEn | input | 1 | Read enable |
| rdAddr | input | 8 | Read byte address |
| rdData | output | 32 | Read data, combinational; zero when no clear-window hit |
| mboxIrq | output | 16 | Nonzero flag per mailbox, indexed core*4+slot |

## Verification
Single-port set patterns check that bits accumulate by OR and do not overwrite. A walk across all sixteen addresses exposes any mix-up in the core/slot index ordering. Partial and lowest-bit-first clears check that only the bits written as 1 are removed and that the flag tracks the last remaining bit. Same-cycle set/clear pairs are driven with the operations on each port in turn, so that port priority is told apart from clear-over-set priority. A dual-port set shows whether one port's data is dropped. Misaligned and out-of-window writes, together with set-window reads, show whether the decode ignores addresses it should ignore.

// File: rtl/mbox_doorbell_pkg.sv
package mbox_doorbell_pkg;

  localparam int MB_CORES    = 4;
  localparam int MB_PER_CORE = 4;
  localparam int MB_NUM      = MB_CORES * MB_PER_CORE;
  localparam int MB_DATA_W   = 32;
  localparam int MB_ADDR_W   = 8;
  localparam int MB_IDX_W    = $clog2(MB_NUM);
  localparam int MB_BYTE_W   = $clog2(MB_DATA_W / 8);
  localparam int MB_WIN_W    = MB_IDX_W + MB_BYTE_W;
  localparam int MB_TAG_W    = MB_ADDR_W - MB_WIN_W;

  typedef logic [MB_DATA_W-1:0] mbWord_t;
  typedef logic [MB_ADDR_W-1:0] mbAddr_t;

  // Per-port write strobes, one select bit per mailbox.
  typedef struct packed {
    logic [MB_NUM-1:0] setSel;
    logic [MB_NUM-1:0] clrSel;
  } mbWrStrobe_t;

  // Read select toward the datapath.
  typedef struct packed {
    logic                rdHit;
    logic [MB_IDX_W-1:0] rdIdx;
  } mbRdStrobe_t;

endpackage

// File: rtl/mbox_doorbell_ctrl.sv
module mbox_doorbell_ctrl
  import mbox_doorbell_pkg::*;
#(
  parameter int      NUM_WR_PORTS = 2,
  parameter mbAddr_t SET_BASE     = 8'h80,
  parameter mbAddr_t CLR_BASE     = 8'hC0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_WR_PORTS-1:0]            wrEn,
  input  logic [NUM_WR_PORTS-1:0][MB_ADDR_W-1:0] wrAddr,
  input  logic                               rdEn,
  input  logic [MB_ADDR_W-1:0]               rdAddr,
  output mbWrStrobe_t                        wrStrobe [NUM_WR_PORTS],
  output mbRdStrobe_t                        rdStrobe
);

  localparam logic [MB_TAG_W-1:0] SET_TAG = SET_BASE[MB_ADDR_W-1:MB_WIN_W];
  localparam logic [MB_TAG_W-1:0] CLR_TAG = CLR_BASE[MB_ADDR_W-1:MB_WIN_W];

  // Write decode: aligned address in one window selects one mailbox.
  always_comb begin
    for (int p = 0; p < NUM_WR_PORTS; p++) begin
      wrStrobe[p].setSel = '0;
      wrStrobe[p].clrSel = '0;
      if (wrEn[p] && (wrAddr[p][MB_BYTE_W-1:0] == '0)) begin
        if (wrAddr[p][MB_ADDR_W-1:MB_WIN_W] == SET_TAG)
          wrStrobe[p].setSel[wrAddr[p][MB_WIN_W-1:MB_BYTE_W]] = 1'b1;
        if (wrAddr[p][MB_ADDR_W-1:MB_WIN_W] == CLR_TAG)
          wrStrobe[p].clrSel[wrAddr[p][MB_WIN_W-1:MB_BYTE_W]] = 1'b1;
      end
    end
  end

  // Read decode: only the clear window returns data.
  always_comb begin
    rdStrobe.rdIdx = rdAddr[MB_WIN_W-1:MB_BYTE_W];
    rdStrobe.rdHit = rdEn && (rdAddr[MB_BYTE_W-1:0] == '0) &&
                     (rdAddr[MB_ADDR_W-1:MB_WIN_W] == CLR_TAG);
  end

  generate
    for (genvar gp = 0; gp < NUM_WR_PORTS; gp++) begin : g_portChk
      assert_set_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wrStrobe[gp].setSel) && $onehot0(wrStrobe[gp].clrSel));

      assert_unaligned_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrAddr[gp][MB_BYTE_W-1:0] != '0) |->
          (wrStrobe[gp].setSel == '0 && wrStrobe[gp].clrSel == '0));
    end
  endgenerate

endmodule

// File: rtl/mbox_doorbell_datapath.sv
module mbox_doorbell_datapath
  import mbox_doorbell_pkg::*;
#(
  parameter int NUM_WR_PORTS = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NUM_WR_PORTS-1:0][MB_DATA_W-1:0]  wrData,
  input  mbWrStrobe_t                             wrStrobe [NUM_WR_PORTS],
  input  mbRdStrobe_t                             rdStrobe,
  output logic [MB_DATA_W-1:0]                    rdData,
  output logic [MB_NUM-1:0]                       mboxIrq
);

  mbWord_t mboxQ  [MB_NUM];
  mbWord_t setAcc [MB_NUM];
  mbWord_t clrAcc [MB_NUM];

  // Merge all ports' set and clear data per mailbox.
  always_comb begin
    for (int i = 0; i < MB_NUM; i++) begin
      setAcc[i] = '0;
      clrAcc[i] = '0;
      for (int p = 0; p < NUM_WR_PORTS; p++) begin
        if (wrStrobe[p].setSel[i]) setAcc[i] = setAcc[i] | wrData[p];
        if (wrStrobe[p].clrSel[i]) clrAcc[i] = clrAcc[i] | wrData[p];
      end
    end
  end

  // Clear is applied after set, so it wins on shared bits.
  always_ff @(posedge clk) begin
    for (int i = 0; i < MB_NUM; i++) begin
      if (!rst_n) mboxQ[i] <= '0;
      else        mboxQ[i] <= (mboxQ[i] | setAcc[i]) & ~clrAcc[i];
    end
  end

  assign rdData = rdStrobe.rdHit ? mboxQ[rdStrobe.rdIdx] : '0;

  generate
    for (genvar gi = 0; gi < MB_NUM; gi++) begin : g_mbox
      assign mboxIrq[gi] = |mboxQ[gi];

      assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (setAcc[gi] != '0) |=>
          ((mboxQ[gi] & $past(setAcc[gi] & ~clrAcc[gi])) == $past(setAcc[gi] & ~clrAcc[gi])));

      assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clrAcc[gi] != '0) |=> ((mboxQ[gi] & $past(clrAcc[gi])) == '0));

      assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (setAcc[gi] == '0 && clrAcc[gi] == '0) |=> $stable(mboxQ[gi]));
    end
  endgenerate

endmodule

// File: rtl/mbox_doorbell_unit.sv
module mbox_doorbell_unit
  import mbox_doorbell_pkg::*;
#(
  parameter int      NUM_WR_PORTS = 2,
  parameter mbAddr_t SET_BASE     = 8'h80,
  parameter mbAddr_t CLR_BASE     = 8'hC0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_WR_PORTS-1:0]           wrEn,
  input  logic [NUM_WR_PORTS*MB_ADDR_W-1:0] wrAddr,
  input  logic [NUM_WR_PORTS*MB_DATA_W-1:0] wrData,
  input  logic                              rdEn,
  input  logic [MB_ADDR_W-1:0]              rdAddr,
  output logic [MB_DATA_W-1:0]              rdData,
  output logic [MB_NUM-1:0]                 mboxIrq
);

  logic [NUM_WR_PORTS-1:0][MB_ADDR_W-1:0] portAddr;
  logic [NUM_WR_PORTS-1:0][MB_DATA_W-1:0] portData;
  mbWrStrobe_t                            wrStrobe [NUM_WR_PORTS];
  mbRdStrobe_t                            rdStrobe;
  logic [MB_NUM-1:0]                      setAny;
  logic [MB_NUM-1:0]                      clrAny;

  generate
    for (genvar gp = 0; gp < NUM_WR_PORTS; gp++) begin : g_unpack
      assign portAddr[gp] = wrAddr[gp*MB_ADDR_W +: MB_ADDR_W];
      assign portData[gp] = wrData[gp*MB_DATA_W +: MB_DATA_W];
    end
  endgenerate

  mbox_doorbell_ctrl #(
    .NUM_WR_PORTS (NUM_WR_PORTS),
    .SET_BASE     (SET_BASE),
    .CLR_BASE     (CLR_BASE)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrAddr   (portAddr),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .wrStrobe (wrStrobe),
    .rdStrobe (rdStrobe)
  );

  mbox_doorbell_datapath #(
    .NUM_WR_PORTS (NUM_WR_PORTS)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrData   (portData),
    .wrStrobe (wrStrobe),
    .rdStrobe (rdStrobe),
    .rdData   (rdData),
    .mboxIrq  (mboxIrq)
  );

  // Per-mailbox activity, used only by the checks below.
  always_comb begin
    setAny = '0;
    clrAny = '0;
    for (int p = 0; p < NUM_WR_PORTS; p++) begin
      setAny = setAny | wrStrobe[p].setSel;
      clrAny = clrAny | wrStrobe[p].clrSel;
    end
  end

  generate
    for (genvar gi = 0; gi < MB_NUM; gi++) begin : g_flagChk
      assert_flag_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mboxIrq[gi]) |-> $past(clrAny[gi]));

      assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mboxIrq[gi]) |-> $past(setAny[gi]));
    end
  endgenerate

  assert_set_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && rdAddr[MB_ADDR_W-1:MB_WIN_W] == SET_BASE[MB_ADDR_W-1:MB_WIN_W]) |-> (rdData == '0));

endmodule

// File: tb/mbox_doorbell_unit_tb.sv
module mbox_doorbell_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  wrEn = '0;
  logic [15:0] wrAddr = '0;
  logic [63:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [15:0] mboxIrq;

  logic [31:0] model [16];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  mbox_doorbell_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .mboxIrq(mboxIrq)
  );

  function automatic logic [7:0] setAt(int c, int m);
    return 8'(8'h80 + 16 * c + 4 * m);
  endfunction

  function automatic logic [7:0] clrAt(int c, int m);
    return 8'(8'hC0 + 16 * c + 4 * m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Spec model: decode one port's write into set/clear masks.
  task automatic modelPort(bit en, logic [7:0] a, logic [31:0] d,
                           ref logic [31:0] s [16], ref logic [31:0] k [16]);
    if (en && a[1:0] == 2'b00 && a >= 8'h80) begin
      if (a < 8'hC0) s[a[5:2]] |= d;
      else           k[a[5:2]] |= d;
    end
  endtask

  task automatic busWrite(bit e0, logic [7:0] a0, logic [31:0] d0,
                          bit e1, logic [7:0] a1, logic [31:0] d1);
    logic [31:0] s [16];
    logic [31:0] k [16];
    @(negedge clk);
    wrEn   = {e1, e0};
    wrAddr = {a1, a0};
    wrData = {d1, d0};
    @(negedge clk);
    wrEn = '0;
    for (int i = 0; i < 16; i++) begin s[i] = '0; k[i] = '0; end
    modelPort(e0, a0, d0, s, k);
    modelPort(e1, a1, d1, s, k);
    for (int i = 0; i < 16; i++) model[i] = (model[i] | s[i]) & ~k[i];
  endtask

  task automatic readCheck(string req, logic [7:0] a, logic [31:0] exp);
    rdAddr = a;
    rdEn   = 1'b1;
    #1;
    check(req, rdData, exp);
    rdEn = 1'b0;
  endtask

  task automatic readVal(logic [7:0] a, output logic [31:0] v);
    rdAddr = a;
    rdEn   = 1'b1;
    #1;
    v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic checkAll(string req);
    logic [15:0] expIrq;
    expIrq = '0;
    for (int i = 0; i < 16; i++) begin
      readCheck(req, 8'(8'hC0 + 4 * i), model[i]);
      expIrq[i] = (model[i] != 0);
    end
    check(req, {16'h0, mboxIrq}, {16'h0, expIrq});
  endtask

  task automatic t_resetState;
    checkAll("R1");
    check("R1", {16'h0, mboxIrq}, 32'h0);
  endtask

  task automatic t_setAccumulate;
    busWrite(1, setAt(2, 1), 32'h0000_0011, 0, 8'h0, 32'h0);
    check("R6", {16'h0, mboxIrq}, 32'h0000_0200);
    busWrite(1, setAt(2, 1), 32'h0000_0100, 0, 8'h0, 32'h0);
    readCheck("R2", clrAt(2, 1), 32'h0000_0111);
    checkAll("R2");
  endtask

  task automatic t_clearLowestFirst;
    logic [31:0] v;
    busWrite(1, clrAt(2, 1), 32'h0000_0010, 0, 8'h0, 32'h0);
    readCheck("R3", clrAt(2, 1), 32'h0000_0101);
    for (int step = 0; step < 2; step++) begin
      readVal(clrAt(2, 1), v);
      busWrite(0, 8'h0, 32'h0, 1, clrAt(2, 1), v & (~v + 32'h1));
      if (step == 0) check("R10", {16'h0, mboxIrq}, 32'h0000_0200);
    end
    readCheck("R10", clrAt(2, 1), 32'h0);
    check("R10", {16'h0, mboxIrq}, 32'h0);
  endtask

  task automatic t_readWindows;
    busWrite(1, setAt(1, 3), 32'hDEAD_BEEF, 0, 8'h0, 32'h0);
    readCheck("R4", clrAt(1, 3), 32'hDEAD_BEEF);
    readCheck("R5", setAt(1, 3), 32'h0);
    readCheck("R5", 8'h40, 32'h0);
    readCheck("R5", 8'hDD, 32'h0);
    busWrite(1, clrAt(1, 3), 32'hFFFF_FFFF, 0, 8'h0, 32'h0);
    readCheck("R3", clrAt(1, 3), 32'h0);
  endtask

  task automatic t_sameCycle;
    busWrite(1, setAt(0, 3), 32'h0000_F000, 0, 8'h0, 32'h0);
    busWrite(1, setAt(0, 3), 32'h0000_00FF, 1, clrAt(0, 3), 32'h0000_F0F0);
    readCheck("R7", clrAt(0, 3), 32'h0000_000F);
    busWrite(1, clrAt(0, 3), 32'h0000_0F0F, 1, setAt(0, 3), 32'h0000_0F00);
    readCheck("R7", clrAt(0, 3), 32'h0);
    check("R7", {16'h0, mboxIrq}, 32'h0);
  endtask

  task automatic t_dualSet;
    busWrite(1, setAt(3, 3), 32'h0000_0001, 1, setAt(3, 3), 32'h8000_0000);
    readCheck("R8", clrAt(3, 3), 32'h8000_0001);
    check("R8", {16'h0, mboxIrq}, 32'h0000_8000);
  endtask

  task automatic t_ignored;
    busWrite(1, 8'h81, 32'hFFFF_FFFF, 1, 8'hFE, 32'hFFFF_FFFF);
    busWrite(1, 8'h40, 32'hFFFF_FFFF, 1, 8'h7C, 32'hFFFF_FFFF);
    busWrite(1, 8'hBD, 32'h1234_5678, 0, 8'h0, 32'h0);
    readCheck("R9", clrAt(3, 3), 32'h8000_0001);
    checkAll("R9");
    check("R9", {16'h0, mboxIrq}, 32'h0000_8000);
  endtask

  task automatic t_walkAll;
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++)
        busWrite(1, setAt(c, m), 32'(c * 4 + m + 1) * 32'h0101_0101, 0, 8'h0, 32'h0);
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++) begin
        logic [31:0] e;
        e = 32'(c * 4 + m + 1) * 32'h0101_0101;
        if (c == 3 && m == 3) e = e | 32'h8000_0001;
        readCheck("R2", clrAt(c, m), e);
      end
    check("R6", {16'h0, mboxIrq}, 32'h0000_FFFF);
    for (int i = 0; i < 16; i += 2)
      busWrite(1, 8'(8'hC0 + 4 * i), 32'hFFFF_FFFF, 1, 8'(8'hC4 + 4 * i), 32'hFFFF_FFFF);
    checkAll("R3");
    check("R6", {16'h0, mboxIrq}, 32'h0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_resetState();
    t_setAccumulate();
    t_clearLowestFirst();
    t_readWindows();
    t_sameCycle();
    t_dualSet();
    t_ignored();
    t_walkAll();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule